// File: doc/BRIEF.md
# Amplifier Mode and Protection Controller

This block is the control sequencer of a two-channel switching audio amplifier. It brings the amplifier out of reset through a timed start-up phase, holds it in a muted state with the modulator running and the bridge undriven, and enables the power stage only after a fixed soft-unmute delay. Muting stops the bridge within a bounded time. The modulator, the bridge and the analog soft-start stay outside this block, which only drives the run and enable controls for them.

Three protection paths feed the sequencer. Two thermal comparator flags raise a warning and a shutdown indication. A third flag reports that the die has cooled below the restore point. A thermal shutdown disables the bridge and clears by itself once that cool flag appears. An overcurrent flag forces the amplifier into mute. That fault stays latched until mute is toggled or reset is applied. Every asynchronous input passes through a two-flop synchronizer. All delays are counted in clock cycles, derived from microsecond targets at a parameterized clock rate of 12288 kHz by default.

Top module: `amp_ctrl_top`

## Requirements
- R1: While rst_n is low, mod_run and stage_en are 0 and err_shut_n, err_warn_n and err_oc_n are 1, whatever the other inputs do. Asserting rst_n takes effect without waiting for a clock edge and clears every latched fault.
- R2: After rst_n rises with mute_n held low, mod_run rises exactly STARTUP_CYC+3 clock cycles later (67 at defaults) and stage_en stays 0.
- R3: When mute_n falls while the stage is running, stage_en falls exactly floor(CLK_KHZ*10/1000) cycles later (122 at defaults, no more than 10 us).
- R4: When mute_n rises with no fault present, stage_en rises exactly floor(CLK_KHZ*34/1000) cycles later (417 at defaults). If mute_n falls again before then, stage_en stays 0.
- R5: err_warn_n goes low 3 cycles after temp_warn rises, and a running stage keeps running.
- R6: err_shut_n goes low 3 cycles after temp_shut rises and stage_en falls 4 cycles after it. mod_run stays 1.
- R7: Both thermal error outputs stay low after their comparators drop until temp_cool is 1. They are released 3 cycles after temp_cool rises, and the stage then restarts after the R4 delay with no mute toggle.
- R8: err_oc_n goes low 3 cycles after ocp_hit rises and stage_en falls 4 cycles after it. The fault remains after ocp_hit falls.
- R9: A latched overcurrent fault is cleared only by a low-to-high transition of mute_n seen while ocp_hit is 0, or by reset. If ocp_hit is still 1 at that transition, the fault stays.
- R10: When an overcurrent fault and a thermal shutdown are present together, stage_en stays 0 until both have cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Amplifier reset, active low, asynchronous assert |
| mute_n | input | 1 | Mute request, active low |
| temp_warn | input | 1 | Die above warning threshold |
| temp_shut | input | 1 | Die above shutdown threshold |
| temp_cool | input | 1 | Die below restore threshold |
| ocp_hit | input | 1 | Any bridge transistor above current limit |
| mod_run | output | 1 | Modulator run enable |
| stage_en | output | 1 | Power bridge drive enable (0 = tri-stated) |
| err_shut_n | output | 1 | Thermal shutdown error, active low |
| err_warn_n | output | 1 | Thermal warning error, active low |
| err_oc_n | output | 1 | Overcurrent error, active low |

## Verification
The hardest situation to reach is the overlap of both faults. In it, the overcurrent latch is cleared by a mute toggle while the die is still hot, so the stage must stay off for thermal reasons alone and then restart unaided once the cool flag arrives. The stimulus table walks this overlap in order: both faults raised, the comparators dropped, mute toggled while hot, and only then cooling. A second case toggles mute while ocp_hit is still high, to show that the set side of the latch wins over the clear.

// File: rtl/amp_ctrl_pkg.sv
`timescale 1ns/1ps
package amp_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_INIT   = 3'd1,
    ST_MUTED  = 3'd2,
    ST_UNMUTE = 3'd3,
    ST_RUN    = 3'd4,
    ST_MUTING = 3'd5
  } amp_state_e;

  // cycles in a given number of microseconds at a clock given in kHz
  function automatic int unsigned us_to_cycles(int unsigned clk_khz, int unsigned us);
    return (clk_khz * us) / 1000;
  endfunction

endpackage

// File: rtl/amp_sync.sv
`timescale 1ns/1ps
module amp_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/amp_delay_timer.sv
`timescale 1ns/1ps
module amp_delay_timer #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt, cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (load)
      cnt_nxt = load_val;
    else if (cnt != '0)
      cnt_nxt = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  assign done = (cnt == '0) && !load;

endmodule

// File: rtl/amp_fault_guard.sv
`timescale 1ns/1ps
module amp_fault_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic warn_s,
  input  logic shut_s,
  input  logic cool_s,
  input  logic ocp_s,
  input  logic mute_s,
  output logic warn_lat,
  output logic shut_lat,
  output logic oc_lat
);

  logic mute_q;
  logic mute_rise;
  logic warn_nxt, shut_nxt, oc_nxt;

  assign mute_rise = mute_s && !mute_q;

  always_comb begin
    // set wins over clear in every latch
    warn_nxt = warn_lat;
    if (warn_s)      warn_nxt = 1'b1;
    else if (cool_s) warn_nxt = 1'b0;

    shut_nxt = shut_lat;
    if (shut_s)      shut_nxt = 1'b1;
    else if (cool_s) shut_nxt = 1'b0;

    oc_nxt = oc_lat;
    if (ocp_s)          oc_nxt = 1'b1;
    else if (mute_rise) oc_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute_q   <= 1'b0;
      warn_lat <= 1'b0;
      shut_lat <= 1'b0;
      oc_lat   <= 1'b0;
    end else begin
      mute_q   <= mute_s;
      warn_lat <= warn_nxt;
      shut_lat <= shut_nxt;
      oc_lat   <= oc_nxt;
    end
  end

  assert_oc_clear_on_mute_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oc_lat) |-> $past(mute_s && !mute_q && !ocp_s))
    else $error("overcurrent latch cleared without a mute release");

  assert_shut_clear_on_cool_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shut_lat) |-> $past(cool_s))
    else $error("thermal shutdown released without cool flag");

endmodule

// File: rtl/amp_ctrl_top.sv
`timescale 1ns/1ps
module amp_ctrl_top
  import amp_ctrl_pkg::*;
#(
  parameter int CLK_KHZ     = 12288,
  parameter int MUTE_US     = 10,
  parameter int UNMUTE_US   = 34,
  parameter int STARTUP_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mute_n,
  input  logic temp_warn,
  input  logic temp_shut,
  input  logic temp_cool,
  input  logic ocp_hit,
  output logic mod_run,
  output logic stage_en,
  output logic err_shut_n,
  output logic err_warn_n,
  output logic err_oc_n
);

  // two synchronizer flops plus the state register
  localparam int LAT        = 3;
  localparam int MUTE_CYC   = int'(us_to_cycles(CLK_KHZ, MUTE_US)) - LAT;
  localparam int UNMUTE_CYC = int'(us_to_cycles(CLK_KHZ, UNMUTE_US)) - LAT;
  localparam int MAX_A      = (MUTE_CYC > UNMUTE_CYC) ? MUTE_CYC : UNMUTE_CYC;
  localparam int MAX_CYC    = (MAX_A > STARTUP_CYC) ? MAX_A : STARTUP_CYC;
  localparam int CW         = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] LD_STARTUP = CW'(STARTUP_CYC - 1);
  localparam logic [CW-1:0] LD_MUTE    = CW'(MUTE_CYC - 1);
  localparam logic [CW-1:0] LD_UNMUTE  = CW'(UNMUTE_CYC - 1);

  logic       rst_int;
  logic [4:0] pins_s;
  logic       mute_s, warn_s, shut_s, cool_s, ocp_s;
  logic       warn_lat, shut_lat, oc_lat, blocked;
  logic       tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;
  amp_state_e state, state_nxt;

  // reset: asserted asynchronously, released through two flops
  amp_sync #(.W(1), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_int)
  );

  amp_sync #(.W(5), .RST_VAL(5'b0)) u_pin_sync (
    .clk(clk), .rst_n(rst_int),
    .d({mute_n, temp_warn, temp_shut, temp_cool, ocp_hit}),
    .q(pins_s)
  );
  assign {mute_s, warn_s, shut_s, cool_s, ocp_s} = pins_s;

  amp_fault_guard u_faults (
    .clk(clk), .rst_n(rst_int),
    .warn_s(warn_s), .shut_s(shut_s), .cool_s(cool_s), .ocp_s(ocp_s), .mute_s(mute_s),
    .warn_lat(warn_lat), .shut_lat(shut_lat), .oc_lat(oc_lat)
  );

  amp_delay_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_int),
    .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  assign blocked = shut_lat || oc_lat;

  always_comb begin
    state_nxt = state;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    case (state)
      ST_OFF: begin
        state_nxt = ST_INIT;
        tmr_load  = 1'b1;
        tmr_val   = LD_STARTUP;
      end
      ST_INIT:
        if (tmr_done) state_nxt = ST_MUTED;
      ST_MUTED:
        if (mute_s && !blocked) begin
          state_nxt = ST_UNMUTE;
          tmr_load  = 1'b1;
          tmr_val   = LD_UNMUTE;
        end
      ST_UNMUTE:
        if (blocked || !mute_s) state_nxt = ST_MUTED;
        else if (tmr_done)      state_nxt = ST_RUN;
      ST_RUN:
        if (blocked) state_nxt = ST_MUTED;
        else if (!mute_s) begin
          state_nxt = ST_MUTING;
          tmr_load  = 1'b1;
          tmr_val   = LD_MUTE;
        end
      ST_MUTING:
        if (blocked || tmr_done) state_nxt = ST_MUTED;
      default:
        state_nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) state <= ST_OFF;
    else          state <= state_nxt;
  end

  assign mod_run    = (state != ST_OFF) && (state != ST_INIT);
  assign stage_en   = (state == ST_RUN) || (state == ST_MUTING);
  assign err_shut_n = !shut_lat;
  assign err_warn_n = !warn_lat;
  assign err_oc_n   = !oc_lat;

  assert_fault_stops_stage_R10: assert property (@(posedge clk) disable iff (!rst_int)
    (oc_lat || shut_lat) |=> !stage_en)
    else $error("bridge driven while a fault is latched");

  assert_stage_needs_mod_R6: assert property (@(posedge clk) disable iff (!rst_int)
    stage_en |-> mod_run)
    else $error("bridge enabled with modulator stopped");

  assert_run_after_delay_R4: assert property (@(posedge clk) disable iff (!rst_int)
    $rose(stage_en) |-> $past(tmr_done))
    else $error("bridge enabled before unmute delay expired");

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_int |-> (!stage_en && !mod_run))
    else $error("outputs active during reset");

endmodule

// File: tb/amp_ctrl_top_test.sv
`timescale 1ns/1ps
module amp_ctrl_top_test;

  logic clk = 1'b0;
  logic rst_n, mute_n, temp_warn, temp_shut, temp_cool, ocp_hit;
  logic mod_run, stage_en, err_shut_n, err_warn_n, err_oc_n;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 0;

  always #2 clk = ~clk;

  amp_ctrl_top uut (
    .clk(clk), .rst_n(rst_n), .mute_n(mute_n),
    .temp_warn(temp_warn), .temp_shut(temp_shut), .temp_cool(temp_cool), .ocp_hit(ocp_hit),
    .mod_run(mod_run), .stage_en(stage_en),
    .err_shut_n(err_shut_n), .err_warn_n(err_warn_n), .err_oc_n(err_oc_n)
  );

  // expected delays, from the requirements at 12288 kHz
  localparam int STARTUP_EDGES = 64 + 3;
  localparam int MUTE_EDGES    = (12288 * 10) / 1000;
  localparam int UNMUTE_EDGES  = (12288 * 34) / 1000;

  // {inputs mute_n,warn,shut,cool,ocp | wait | expect mod,stage,shut_n,warn_n,oc_n | req}
  localparam int NV = 19;
  localparam logic [23:0] VEC [NV] = '{
    {5'b10010, 10'd500, 5'b11111, 4'd4},   // unmute to running
    {5'b11000, 10'd10,  5'b11101, 4'd5},   // warning only, keeps running
    {5'b11100, 10'd10,  5'b10001, 4'd6},   // shutdown
    {5'b10000, 10'd10,  5'b10001, 4'd7},   // comparators drop, not yet cool
    {5'b10010, 10'd10,  5'b10111, 4'd7},   // cool: flags released, delay running
    {5'b10010, 10'd500, 5'b11111, 4'd7},   // automatic restart
    {5'b10011, 10'd10,  5'b10110, 4'd8},   // overcurrent
    {5'b10010, 10'd500, 5'b10110, 4'd8},   // stays latched
    {5'b00010, 10'd10,  5'b10110, 4'd9},   // mute asserted, still latched
    {5'b10010, 10'd500, 5'b11111, 4'd9},   // mute released: cleared, running
    {5'b11101, 10'd10,  5'b10000, 4'd10},  // both faults
    {5'b11000, 10'd10,  5'b10000, 4'd10},  // comparators drop, hot
    {5'b01000, 10'd10,  5'b10000, 4'd10},  // mute asserted while hot
    {5'b11000, 10'd500, 5'b10001, 4'd10},  // oc cleared, thermal holds stage off
    {5'b10010, 10'd500, 5'b11111, 4'd10},  // cool: restart
    {5'b00010, 10'd200, 5'b10111, 4'd3},   // muted
    {5'b00011, 10'd10,  5'b10110, 4'd8},   // overcurrent while muted
    {5'b10011, 10'd500, 5'b10110, 4'd9},   // mute release during overcurrent
    {5'b10010, 10'd500, 5'b10110, 4'd9}    // still latched
  };

  task automatic drive(input logic [4:0] v);
    @(negedge clk);
    {mute_n, temp_warn, temp_shut, temp_cool, ocp_hit} = v;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [4:0] exp);
    logic [4:0] got;
    got = {mod_run, stage_en, err_shut_n, err_warn_n, err_oc_n};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (mod,stage,shut_n,warn_n,oc_n)", req, got, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {mute_n, temp_warn, temp_shut, temp_cool, ocp_hit} = 5'b00010;
    edges(5);
    check("R1 reset state", 5'b00111);
    drive(5'b01101);            // faults during reset are ignored
    edges(5);
    check("R1 faults in reset", 5'b00111);
    drive(5'b00010);

    // R2 start-up timing
    @(negedge clk);
    rst_n = 1'b1;
    edges(STARTUP_EDGES - 1);
    check("R2 start-up not done", 5'b00111);
    edges(1);
    check("R2 start-up done", 5'b10111);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][23:19]);
      edges(int'(VEC[i][18:9]));
      check($sformatf("R%0d vector %0d", VEC[i][3:0], i), VEC[i][8:4]);
    end

    // reset mid-fault: asynchronous, clears the overcurrent latch (R1, R9)
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 R9 async reset clears", 5'b00111);
    drive(5'b00010);
    @(negedge clk);
    rst_n = 1'b1;
    edges(STARTUP_EDGES + 3);
    check("R2 muted after restart", 5'b10111);

    // R4 exact unmute delay
    drive(5'b10010);
    edges(UNMUTE_EDGES - 1);
    check("R4 one cycle before unmute", 5'b10111);
    edges(1);
    check("R4 unmute edge", 5'b11111);

    // R3 exact mute delay
    drive(5'b00010);
    edges(MUTE_EDGES - 1);
    check("R3 one cycle before mute", 5'b11111);
    edges(1);
    check("R3 mute edge", 5'b10111);

    // R4 unmute aborted by re-mute
    drive(5'b10010);
    edges(200);
    drive(5'b00010);
    edges(400);
    check("R4 aborted unmute", 5'b10111);

    // R8 overcurrent latency
    drive(5'b10010);
    edges(UNMUTE_EDGES + 2);
    check("R4 running before fault", 5'b11111);
    drive(5'b10011);
    edges(2);
    check("R8 before latch", 5'b11111);
    edges(1);
    check("R8 error flagged", 5'b11110);
    edges(1);
    check("R8 stage stopped", 5'b10110);

    // clear and run again, then R5/R6 shutdown latency
    drive(5'b00010);
    edges(6);
    drive(5'b10010);
    edges(UNMUTE_EDGES + 4);
    check("R9 cleared and running", 5'b11111);
    drive(5'b11100);
    edges(3);
    check("R5 R6 errors flagged", 5'b11001);
    edges(1);
    check("R6 stage stopped", 5'b10001);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule